// File: doc/BRIEF.md
# Two-Term Power-of-Two Weight Multiplier

This block forms the product of a signed fixed-point activation and a 6-bit compressed weight. In shift-add mode the weight is not a number. It is a sign bit and two small exponent codes. Each nonzero code selects a left-shifted copy of the activation. The two copies are added, and the sign bit then negates the sum when it is set. No multiplier is used on this path. In multiply mode the same 6-bit word is read as an ordinary two's-complement integer, and the block multiplies by it directly. That mode serves layers whose weights are evenly spaced.

The mode is held for a whole layer. It is loaded only on a layer-start pulse, so a mode input that wanders mid-layer has no effect. The input side is a valid/ready port that carries the activation and the weight. The output is a registered product with a valid flag, two cycles after acceptance in either mode. Results therefore leave in the order they arrived, one per cycle.

Top module: `mp2_mul_top`

## Requirements
- R1: While `rstN` is low, `inReady` and `outValid` are 0 and `productOut` is 0. After reset `inReady` is 1 on every cycle, and the mode is multiply.
- R2: Field positions in `wgtIn` are: bit 5 is the sign, bits 4:2 are the primary code, and bits 1:0 are the secondary code.
- R3: In shift-add mode, a code value k > 0 contributes the activation shifted left by k-1. A code of 0 contributes nothing. A weight whose two codes are both 0 gives a product of 0 for either sign.
- R4: In shift-add mode the two contributions are summed first. A sign bit of 1 then negates the whole sum, so weights differing only in bit 5 give products of opposite sign.
- R5: Weight 6'b101101 in shift-add mode gives -(4·a + a) = -5·a for activation a.
- R6: `modeSel` = 1 selects shift-add. `modeSel` = 0 selects multiply, where the product is `actIn` times `wgtIn` read as a signed 6-bit integer.
- R7: The mode is loaded from `modeSel` only on a cycle with `layerStart` = 1, and a beat accepted in that same cycle already uses the new mode. On every other cycle, changes on `modeSel` are ignored.
- R8: A beat accepted at clock edge n appears on `productOut` with `outValid` = 1 after edge n+1, in both modes. `outValid` is 0 for cycles with no such beat. Back-to-back beats emerge back-to-back and in order.
- R9: `productOut` is a 24-bit signed value and holds the exact result for every activation from -32768 to 32767, including the largest shift of 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| layerStart | input | 1 | Pulse that loads the layer mode |
| modeSel | input | 1 | 1 = shift-add, 0 = multiply; sampled with `layerStart` |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Block can take a beat |
| actIn | input | 16 | Signed activation |
| wgtIn | input | 6 | Compressed weight: sign, primary code, secondary code |
| outValid | output | 1 | `productOut` holds a new result |
| productOut | output | 24 | Signed product |

## Verification
The bench uses the default parameters: a 16-bit activation, a 3-bit primary code, a 2-bit secondary code and a 24-bit product. With these widths the whole weight space is only 64 words. The bench therefore runs every sign, primary and secondary combination in shift-add mode against several activations, including both ends of the signed range, where the shift of 6 sits closest to the output width. The same default widths keep multiply-mode products of the extreme operands well inside 24 bits. This lets the mode-switch and ignored-mode checks tell the two paths apart by value.

// File: rtl/mp2_pkg.sv
package mp2_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureIn;  // load stage 1 from the ports
    logic advance;    // load stage 2 (result register)
    logic shiftPath;  // beat being captured uses shift-add
  } mp2Strobes_t;

endpackage

// File: rtl/mp2_ctrl.sv
module mp2_ctrl
  import mp2_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        layerStart,
  input  logic        modeSel,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  output mp2Strobes_t strobes
);

  logic readyReg;
  logic modeReg;     // 1 = shift-add, 0 = multiply
  logic stage1Vld;
  logic stage2Vld;
  logic accept;
  logic effMode;

  assign accept  = inValid && readyReg;
  assign effMode = layerStart ? modeSel : modeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyReg  <= 1'b0;
      modeReg   <= 1'b0;
      stage1Vld <= 1'b0;
      stage2Vld <= 1'b0;
    end else begin
      readyReg  <= 1'b1;
      if (layerStart) modeReg <= modeSel;
      stage1Vld <= accept;
      stage2Vld <= stage1Vld;
    end
  end

  assign inReady           = readyReg;
  assign outValid          = stage2Vld;
  assign strobes.captureIn = accept;
  assign strobes.advance   = stage1Vld;
  assign strobes.shiftPath = effMode;

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !layerStart |=> $stable(modeReg));

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid && inReady, 2));

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReady);

endmodule

// File: rtl/mp2_datapath.sv
module mp2_datapath
  import mp2_pkg::*;
#(
  parameter int ACT_W  = 16,
  parameter int PRI_W  = 3,
  parameter int SEC_W  = 2,
  parameter int PROD_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mp2Strobes_t              strobes,
  input  logic signed [ACT_W-1:0]  actIn,
  input  logic [PRI_W+SEC_W:0]     wgtIn,
  output logic signed [PROD_W-1:0] productOut
);

  localparam int WGT_W  = 1 + PRI_W + SEC_W;
  localparam int SIGN_B = WGT_W - 1;
  localparam int MUL_W  = ACT_W + WGT_W;
  localparam int NTERM  = 2;
  localparam int FW  [NTERM] = '{SEC_W, PRI_W};
  localparam int FLO [NTERM] = '{0, SEC_W};

  logic signed [PROD_W-1:0] extAct;
  logic signed [PROD_W-1:0] termNext [NTERM];
  logic signed [PROD_W-1:0] termReg  [NTERM];
  logic                     negReg;
  logic                     shiftReg;
  logic signed [ACT_W-1:0]  actReg;
  logic signed [WGT_W-1:0]  wgtReg;
  logic signed [MUL_W-1:0]  mulFull;
  logic signed [PROD_W-1:0] mulExt;
  logic signed [PROD_W-1:0] magSum;
  logic signed [PROD_W-1:0] resultNext;

  assign extAct = {{(PROD_W-ACT_W){actIn[ACT_W-1]}}, actIn};

  // One shifter per weight code field
  for (genvar g = 0; g < NTERM; g++) begin : gTerm
    localparam int CW = FW[g];
    logic [CW-1:0] code;
    assign code = wgtIn[FLO[g] +: CW];
    always_comb begin
      if (code == '0) termNext[g] = '0;
      else            termNext[g] = extAct <<< (code - 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NTERM; i++) termReg[i] <= '0;
      negReg   <= 1'b0;
      shiftReg <= 1'b0;
      actReg   <= '0;
      wgtReg   <= '0;
    end else if (strobes.captureIn) begin
      for (int i = 0; i < NTERM; i++) termReg[i] <= termNext[i];
      negReg   <= wgtIn[SIGN_B];
      shiftReg <= strobes.shiftPath;
      actReg   <= actIn;
      wgtReg   <= wgtIn;
    end
  end

  assign mulFull = actReg * wgtReg;
  assign mulExt  = {{(PROD_W-MUL_W){mulFull[MUL_W-1]}}, mulFull};

  always_comb begin
    magSum = '0;
    for (int i = 0; i < NTERM; i++) magSum = magSum + termReg[i];
    if (shiftReg) resultNext = negReg ? -magSum : magSum;
    else          resultNext = mulExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                productOut <= '0;
    else if (strobes.advance) productOut <= resultNext;
  end

  // R3
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureIn && strobes.shiftPath && wgtIn[SIGN_B-1:0] == '0)
      |=> ##1 (productOut == '0));

  // R4
  sign_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureIn && strobes.shiftPath && wgtIn[SIGN_B] && !actIn[ACT_W-1])
      |=> ##1 (productOut <= 0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureIn && strobes.shiftPath && actIn[ACT_W-1] && !wgtIn[SIGN_B]
      && wgtIn[SIGN_B-1:0] != '0) |=> ##1 (productOut < 0));

endmodule

// File: rtl/mp2_mul_top.sv
module mp2_mul_top
  import mp2_pkg::*;
#(
  parameter int ACT_W  = 16,
  parameter int PRI_W  = 3,
  parameter int SEC_W  = 2,
  parameter int PROD_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     layerStart,
  input  logic                     modeSel,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [ACT_W-1:0]  actIn,
  input  logic [PRI_W+SEC_W:0]     wgtIn,
  output logic                     outValid,
  output logic signed [PROD_W-1:0] productOut
);

  mp2Strobes_t strobes;

  mp2_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .layerStart (layerStart),
    .modeSel    (modeSel),
    .inValid    (inValid),
    .inReady    (inReady),
    .outValid   (outValid),
    .strobes    (strobes)
  );

  mp2_datapath #(
    .ACT_W  (ACT_W),
    .PRI_W  (PRI_W),
    .SEC_W  (SEC_W),
    .PROD_W (PROD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .actIn      (actIn),
    .wgtIn      (wgtIn),
    .productOut (productOut)
  );

endmodule

// File: tb/mp2_mul_top_bench.sv
module mp2_mul_top_bench;

  logic               clk = 1'b0;
  logic               rstN;
  logic               layerStart;
  logic               modeSel;
  logic               inValid;
  logic               inReady;
  logic signed [15:0] actIn;
  logic [5:0]         wgtIn;
  logic               outValid;
  logic signed [23:0] productOut;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mp2_mul_top u_mp2_mul_top (
    .clk(clk), .rstN(rstN), .layerStart(layerStart), .modeSel(modeSel),
    .inValid(inValid), .inReady(inReady), .actIn(actIn), .wgtIn(wgtIn),
    .outValid(outValid), .productOut(productOut)
  );

  function automatic int refShift(int a, logic [5:0] w);
    int p = int'(w[4:2]);
    int s = int'(w[1:0]);
    int m = 0;
    if (p > 0) m += a * (1 << (p - 1));
    if (s > 0) m += a * (1 << (s - 1));
    return w[5] ? -m : m;
  endfunction

  function automatic int refMul(int a, logic [5:0] w);
    return a * int'($signed(w));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (int'(productOut) != exp) begin
      errs++;
      $display("FAIL %s act=%0d actual=%0d expected=%0d", tag, act, productOut, exp);
    end
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic setMode(logic m);
    @(negedge clk);
    layerStart = 1'b1; modeSel = m;
    @(negedge clk);
    layerStart = 1'b0;
  endtask

  // Single beat: accept edge, result after the next edge
  task automatic sendOne(string tag, int a, logic [5:0] w, int exp);
    @(negedge clk);
    actIn = 16'(a); wgtIn = w; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit({tag, " R8 early"}, outValid, 1'b0);
    @(negedge clk);
    checkBit({tag, " R8 valid"}, outValid, 1'b1);
    check(tag, a, exp);
  endtask

  task automatic testReset();
    rstN = 1'b0; layerStart = 0; modeSel = 0; inValid = 1; actIn = 16'sd7; wgtIn = 6'h3f;
    repeat (3) @(negedge clk);
    checkBit("R1 inReady in reset", inReady, 1'b0);
    checkBit("R1 outValid in reset", outValid, 1'b0);
    check("R1 product in reset", 7, 0);
    inValid = 0;
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 inReady after reset", inReady, 1'b1);
    sendOne("R1 default multiply mode", 7, 6'b101101, refMul(7, 6'b101101));
  endtask

  task automatic testFields();
    setMode(1'b1);
    sendOne("R2 primary only", 3, 6'b010000, 3 * 8);
    sendOne("R2 secondary only", 3, 6'b000011, 3 * 4);
    sendOne("R2 sign only", 3, 6'b100000, 0);
    sendOne("R5 example weight", 100, 6'b101101, -500);
    sendOne("R5 example weight neg act", -7, 6'b101101, 35);
  endtask

  task automatic testExhaustive();
    int acts [5] = '{1, -3, 1234, -32768, 32767};
    setMode(1'b1);
    for (int wi = 0; wi < 64; wi++) begin
      for (int ai = 0; ai < 5; ai++) begin
        sendOne("R3 R4 R9 shift-add", acts[ai], 6'(wi), refShift(acts[ai], 6'(wi)));
      end
    end
  endtask

  task automatic testMultiply();
    setMode(1'b0);
    sendOne("R6 multiply pos", 1000, 6'b011111, 31000);
    sendOne("R6 multiply neg w", 1000, 6'b100000, -32000);
    sendOne("R6 multiply extreme", -32768, 6'b100000, 1048576);
    sendOne("R6 multiply mid", -123, 6'b101101, refMul(-123, 6'b101101));
  endtask

  task automatic testModeHold();
    setMode(1'b1);
    @(negedge clk); modeSel = 1'b0;
    sendOne("R7 ignored modeSel change", 11, 6'b101101, -55);
    @(negedge clk); modeSel = 1'b1;
    setMode(1'b0);
    @(negedge clk); modeSel = 1'b1;
    sendOne("R7 ignored modeSel change mul", 11, 6'b101101, -209);
    // layerStart coincident with a beat
    @(negedge clk);
    layerStart = 1'b1; modeSel = 1'b1;
    actIn = 16'sd9; wgtIn = 6'b101101; inValid = 1'b1;
    @(negedge clk);
    layerStart = 1'b0; inValid = 1'b0;
    @(negedge clk);
    checkBit("R7 same-cycle valid", outValid, 1'b1);
    check("R7 same-cycle new mode", 9, -45);
  endtask

  task automatic testBurst();
    int         a [8] = '{5, -6, 77, -32768, 32767, 0, 13, -2};
    logic [5:0] w [8] = '{6'b011111, 6'b111111, 6'b000101, 6'b011111,
                          6'b111111, 6'b010101, 6'b100001, 6'b001010};
    setMode(1'b1);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        checkBit("R8 burst valid", outValid, 1'b1);
        check("R8 burst order", a[j-2], refShift(a[j-2], w[j-2]));
      end
      if (j < 8) begin
        actIn = 16'(a[j]); wgtIn = w[j]; inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    checkBit("R8 burst drained", outValid, 1'b0);
  endtask

  initial begin
    testReset();
    testFields();
    testExhaustive();
    testMultiply();
    testModeHold();
    testBurst();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule